// File: doc/BRIEF.md
# Fixed-Latency Arbitrated Write Port

A small word-addressed store, built as lines of four 32-bit words, is shared by three requesters: an instruction-fetch stage, a data-memory stage and a first-level cache. A fourth, privileged side port can write at any time. Every cycle each requester may present a write (address and data), and the block answers each one in the same cycle with OK (`req_ok` bit high) or WAIT (`req_valid` high, `req_ok` low). Only one access is in service at a time. The requester that owns the port has to keep re-presenting the same write. It is told WAIT on `DELAY` of those presentations and OK on the one after.

Requesters that are waiting are kept in the order in which they first asked. Requesters that first ask in the same cycle are ordered by their index. The side port skips both arbitration and latency: its write is acknowledged at once. A read-only view of one line at a time is provided for test.

Top module: `fixed_latency_mem_port`

## Requirements
- R1: While reset is held and immediately after it, every word of storage reads zero through `dbg_view` and no `req_ok` bit is high.
- R2: An owner gets WAIT on exactly `DELAY` cycles in which it presents its request, and OK on the next such cycle. Cycles in which it does not present are not counted. Its data is written at the clock edge that ends the OK cycle.
- R3: While a request gets WAIT, the word it addresses keeps its old value.
- R4: At most one `req_ok` bit is high in a cycle. Every other presenting requester gets WAIT, also in the cycle in which the owner gets OK. The next owner's count starts from zero in the following cycle.
- R5: Ownership passes in the order in which requesters first received WAIT. A requester that asked in an earlier cycle is served before one with a lower index that asked later.
- R6: Requesters that first ask in the same cycle are queued by index, lowest first. Index 0 is fetch, 1 is data memory and 2 is cache, and these are the bit positions in `req_valid`, `req_ok` and the packed address and data buses.
- R7: With `DELAY` = 0, a request to an idle port gets OK in the cycle it is presented.
- R8: A side write (`side_valid` high) gets `side_ok` in the same cycle whatever the state of arbitration. Its data is in storage after the next clock edge.
- R9: A side write neither resets nor advances the owner's latency count.
- R10: Word address `a` selects line `a >> 2`, word `a[1:0]`. `dbg_view` bits `32k+31:32k` hold word `k` of the line selected by `dbg_line`.
- R11: If a side write and an OK write hit the same word at the same edge, the side data is the value kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NREQ | Requester i presents a write this cycle |
| req_addr | input | NREQ*AW | Packed word addresses, requester i at bits i*AW |
| req_data | input | NREQ*32 | Packed write data, requester i at bits i*32 |
| req_ok | output | NREQ | Combinational OK for each requester |
| side_valid | input | 1 | Side-port write request |
| side_addr | input | AW | Side-port word address |
| side_data | input | 32 | Side-port write data |
| side_ok | output | 1 | Side-port acknowledge |
| dbg_line | input | LW | Line selected for the debug view |
| dbg_view | output | 128 | The four words of the selected line |

## Verification
The assertions assume that every address is in range, which holds because `LINES` is a power of two, so the address width covers storage exactly. They also assume that a requester waiting in the queue does not change its address or data before it is granted. The stimulus keeps each requester's address and data fixed for the whole of its access, and it changes inputs only on the falling clock edge. Because of this, each combinational answer and each registered write can be checked in a known cycle.

// File: rtl/flmp_pkg.sv
package flmp_pkg;

  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int VIEW_W     = WORD_W * LINE_WORDS;

  typedef enum logic [1:0] {
    RQ_FETCH = 2'd0,
    RQ_MEM   = 2'd1,
    RQ_L1    = 2'd2,
    RQ_SIDE  = 2'd3
  } rq_id_e;

  // Word position inside a line: the two low address bits.
  function automatic int unsigned lane_of(input logic [31:0] addr);
    return int'(addr[1:0]);
  endfunction

  // Line holding a word address.
  function automatic int unsigned line_of(input logic [31:0] addr);
    return int'(addr >> 2);
  endfunction

  // Flat storage index of word k of a line.
  function automatic int unsigned flat_index(input int unsigned line,
                                             input int unsigned lane);
    return line * LINE_WORDS + lane;
  endfunction

  // Latency count update: cleared on completion, bumped on a presentation.
  function automatic int unsigned lat_next(input int unsigned cnt,
                                           input logic present,
                                           input logic finish);
    if (finish)       return 0;
    else if (present) return cnt + 1;
    else              return cnt;
  endfunction

endpackage

// File: rtl/arb_order_queue.sv
module arb_order_queue #(
  parameter int NREQ = 3,
  parameter int IDW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] arrive,
  input  logic            pop,
  output logic [IDW-1:0]  head_id,
  output logic            empty,
  output logic [NREQ-1:0] member
);

  localparam int OW = $clog2(NREQ + 1);

  logic [IDW-1:0] slot_q [NREQ];
  logic [IDW-1:0] slot_d [NREQ];
  logic [OW-1:0]  occ_q;
  logic [OW-1:0]  occ_d;
  logic [NREQ-1:0] member_d;

  always_comb begin
    int n;
    n = int'(occ_q);
    for (int k = 0; k < NREQ; k++) slot_d[k] = slot_q[k];
    member_d = member;
    if (pop && n > 0) begin
      for (int k = 0; k < NREQ - 1; k++) slot_d[k] = slot_q[k + 1];
      slot_d[NREQ-1] = '0;
      for (int i = 0; i < NREQ; i++)
        if (slot_q[0] == IDW'(i)) member_d[i] = 1'b0;
      n = n - 1;
    end
    for (int i = 0; i < NREQ; i++) begin
      if (arrive[i] && n < NREQ) begin
        slot_d[n]   = IDW'(i);
        member_d[i] = 1'b1;
        n = n + 1;
      end
    end
    occ_d = OW'(n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREQ; k++) slot_q[k] <= '0;
      occ_q  <= '0;
      member <= '0;
    end else begin
      for (int k = 0; k < NREQ; k++) slot_q[k] <= slot_d[k];
      occ_q  <= occ_d;
      member <= member_d;
    end
  end

  assign head_id = slot_q[0];
  assign empty   = (occ_q == '0);

endmodule

// File: rtl/arb_latency_ctr.sv
module arb_latency_ctr
  import flmp_pkg::*;
#(
  parameter int DELAY = 3,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          present,
  input  logic          finish,
  output logic [CW-1:0] cnt,
  output logic          at_limit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CW'(lat_next(int'(cnt), present, finish));
  end

  assign at_limit = (cnt == CW'(DELAY));

endmodule

// File: rtl/arb_word_store.sv
module arb_word_store
  import flmp_pkg::*;
#(
  parameter int LINES = 4,
  parameter int AW    = 4,
  parameter int LW    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      a_en,
  input  logic [AW-1:0]             a_addr,
  input  logic [WORD_W-1:0]         a_data,
  input  logic                      b_en,
  input  logic [AW-1:0]             b_addr,
  input  logic [WORD_W-1:0]         b_data,
  input  logic [LW-1:0]             view_line,
  output logic [VIEW_W-1:0]         view_words,
  output logic [LINES*VIEW_W-1:0]   all_words
);

  localparam int WORDS = LINES * LINE_WORDS;

  logic [WORD_W-1:0] words [WORDS];

  // Port b (side) is applied last, so it wins on a shared word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else begin
      if (a_en)
        words[flat_index(line_of(32'(a_addr)), lane_of(32'(a_addr)))] <= a_data;
      if (b_en)
        words[flat_index(line_of(32'(b_addr)), lane_of(32'(b_addr)))] <= b_data;
    end
  end

  generate
    for (genvar k = 0; k < LINE_WORDS; k++) begin : g_view
      assign view_words[k*WORD_W +: WORD_W] =
        words[flat_index(int'(view_line), k)];
    end
    for (genvar i = 0; i < WORDS; i++) begin : g_flat
      assign all_words[i*WORD_W +: WORD_W] = words[i];
    end
  endgenerate

endmodule

// File: rtl/fixed_latency_mem_port.sv
module fixed_latency_mem_port
  import flmp_pkg::*;
#(
  parameter int NREQ  = 3,
  parameter int DELAY = 3,
  parameter int LINES = 4,
  localparam int AW   = $clog2(LINES * 4),
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREQ-1:0]        req_valid,
  input  logic [NREQ*AW-1:0]     req_addr,
  input  logic [NREQ*32-1:0]     req_data,
  output logic [NREQ-1:0]        req_ok,
  input  logic                   side_valid,
  input  logic [AW-1:0]          side_addr,
  input  logic [31:0]            side_data,
  output logic                   side_ok,
  input  logic [LW-1:0]          dbg_line,
  output logic [127:0]           dbg_view
);

  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int CW  = $clog2(DELAY + 2);
  localparam int SW  = LINES * VIEW_W;

  // Named internal events, used by the bound checker.
  logic [IDW-1:0]  q_head;
  logic            q_empty;
  logic [NREQ-1:0] q_member;
  logic [IDW-1:0]  head_sel;
  logic [IDW-1:0]  low_id;
  logic            head_present;
  logic            at_limit;
  logic            grant_ok;
  logic            q_pop;
  logic [NREQ-1:0] arrive;
  logic [CW-1:0]   lat_cnt;
  logic [AW-1:0]   wr_addr;
  logic [31:0]     wr_data;
  logic [SW-1:0]   store_flat;

  // Owner: queue head, or the lowest presenting index when the queue is empty.
  always_comb begin
    low_id = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (req_valid[i]) low_id = IDW'(i);
    head_sel     = q_empty ? low_id : q_head;
    head_present = 1'b0;
    wr_addr      = '0;
    wr_data      = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (head_sel == IDW'(i)) begin
        head_present = req_valid[i];
        wr_addr      = req_addr[i*AW +: AW];
        wr_data      = req_data[i*32 +: 32];
      end
    end
  end

  assign grant_ok = head_present & at_limit;
  assign q_pop    = grant_ok & ~q_empty;

  always_comb begin
    for (int i = 0; i < NREQ; i++)
      req_ok[i] = grant_ok && (head_sel == IDW'(i));
  end

  assign arrive  = req_valid & ~q_member & ~req_ok;
  assign side_ok = side_valid;

  arb_order_queue #(
    .NREQ (NREQ),
    .IDW  (IDW)
  ) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .arrive  (arrive),
    .pop     (q_pop),
    .head_id (q_head),
    .empty   (q_empty),
    .member  (q_member)
  );

  arb_latency_ctr #(
    .DELAY (DELAY),
    .CW    (CW)
  ) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .present  (head_present),
    .finish   (grant_ok),
    .cnt      (lat_cnt),
    .at_limit (at_limit)
  );

  arb_word_store #(
    .LINES (LINES),
    .AW    (AW),
    .LW    (LW)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_en       (grant_ok),
    .a_addr     (wr_addr),
    .a_data     (wr_data),
    .b_en       (side_valid),
    .b_addr     (side_addr),
    .b_data     (side_data),
    .view_line  (dbg_line),
    .view_words (dbg_view),
    .all_words  (store_flat)
  );

endmodule

// File: rtl/flmp_chk.sv
module flmp_chk #(
  parameter int NREQ  = 3,
  parameter int DELAY = 3,
  parameter int CW    = 2,
  parameter int SW    = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] req_ok,
  input logic            side_valid,
  input logic            side_ok,
  input logic            grant_ok,
  input logic            q_empty,
  input logic [CW-1:0]   lat_cnt,
  input logic [SW-1:0]   store_flat
);

  // R4: never more than one OK per cycle
  a_r4_single_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ok));

  // R4: OK only goes to a requester that is presenting
  a_r4_ok_only_presented: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_ok & ~req_valid) == '0));

  // R2: OK only once the owner's count reached DELAY
  a_r2_ok_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ok) |-> (lat_cnt == CW'(DELAY)));

  // R4: next owner starts counting from zero
  a_r4_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ok |=> (lat_cnt == '0));

  // R3: with no OK and no side write, storage does not move
  a_r3_wait_holds_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req_ok) && !side_valid) |=> $stable(store_flat));

  // R8: side write is acknowledged in the same cycle
  a_r8_side_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    side_valid |-> side_ok);

  // R4: a busy port answers nobody until the owner completes
  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && !grant_ok) |-> (req_ok == '0));

endmodule

bind fixed_latency_mem_port flmp_chk #(
  .NREQ  (NREQ),
  .DELAY (DELAY),
  .CW    (CW),
  .SW    (SW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ok     (req_ok),
  .side_valid (side_valid),
  .side_ok    (side_ok),
  .grant_ok   (grant_ok),
  .q_empty    (q_empty),
  .lat_cnt    (lat_cnt),
  .store_flat (store_flat)
);

// File: tb/fixed_latency_mem_port_test.sv
`timescale 1ns/1ps
module fixed_latency_mem_port_test;

  localparam int NREQ  = 3;
  localparam int DELAY = 3;
  localparam int LINES = 4;
  localparam int AW    = 4;
  localparam int LW    = 2;

  localparam logic [31:0] D_FETCH = 32'hAAAA_0001;
  localparam logic [31:0] D_MEM   = 32'hBBBB_0000;
  localparam logic [31:0] D_L1    = 32'hCCCC_0002;

  // {valid[2:0], expected ok[2:0]}; bit0 fetch, bit1 mem, bit2 cache, DELAY=3
  localparam logic [5:0] VEC [0:29] = '{
    {3'b010, 3'b000}, {3'b011, 3'b000}, {3'b011, 3'b000}, {3'b111, 3'b010},
    {3'b101, 3'b000}, {3'b101, 3'b000}, {3'b101, 3'b000}, {3'b101, 3'b001},
    {3'b100, 3'b000}, {3'b000, 3'b000}, {3'b100, 3'b000}, {3'b100, 3'b000},
    {3'b100, 3'b100}, {3'b110, 3'b000}, {3'b100, 3'b000}, {3'b010, 3'b000},
    {3'b010, 3'b000}, {3'b010, 3'b010}, {3'b100, 3'b000}, {3'b100, 3'b000},
    {3'b100, 3'b000}, {3'b100, 3'b100}, {3'b100, 3'b000}, {3'b101, 3'b000},
    {3'b101, 3'b000}, {3'b101, 3'b100}, {3'b001, 3'b000}, {3'b001, 3'b000},
    {3'b001, 3'b000}, {3'b001, 3'b001}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NREQ-1:0]     req_valid = '0;
  logic [NREQ*AW-1:0]  req_addr = '0;
  logic [NREQ*32-1:0]  req_data = '0;
  logic [NREQ-1:0]     req_ok, req_ok0;
  logic                side_valid = 1'b0;
  logic [AW-1:0]       side_addr = '0;
  logic [31:0]         side_data = '0;
  logic                side_ok, side_ok0;
  logic [LW-1:0]       dbg_line = '0;
  logic [127:0]        view, view0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fixed_latency_mem_port #(.NREQ(NREQ), .DELAY(DELAY), .LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ok(req_ok), .side_valid(side_valid),
    .side_addr(side_addr), .side_data(side_data), .side_ok(side_ok),
    .dbg_line(dbg_line), .dbg_view(view)
  );

  fixed_latency_mem_port #(.NREQ(NREQ), .DELAY(0), .LINES(LINES)) uut_d0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ok(req_ok0), .side_valid(side_valid),
    .side_addr(side_addr), .side_data(side_data), .side_ok(side_ok0),
    .dbg_line(dbg_line), .dbg_view(view0)
  );

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_req(input int i, input logic [AW-1:0] a, input logic [31:0] d);
    req_addr[i*AW +: AW] = a;
    req_data[i*32 +: 32] = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = '0; side_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apply(input logic [2:0] v);
    @(negedge clk);
    req_valid = v;
    #1;
  endtask

  initial begin
    // R1: reset state
    do_reset();
    #1;
    check("R1 no ok after reset", req_ok, 3'b000);
    for (int ln = 0; ln < LINES; ln++) begin
      dbg_line = LW'(ln);
      #1;
      check($sformatf("R1 line %0d zero", ln), view, 128'h0);
    end

    // Table walk: ordering, latency, arrival priority
    set_req(0, 4'd1, D_FETCH);
    set_req(1, 4'd0, D_MEM);
    set_req(2, 4'd2, D_L1);
    for (int k = 0; k < 30; k++) begin
      apply(VEC[k][5:3]);
      check($sformatf("R2 R4 R5 R6 vector %0d ok", k), req_ok, VEC[k][2:0]);
    end
    @(negedge clk);
    req_valid = '0; dbg_line = '0;
    #1;
    check("R2 R10 line 0 contents", view, {32'h0, D_L1, D_FETCH, D_MEM});

    // R3 R8 R9: side write in the middle of an access
    do_reset();
    set_req(1, 4'd5, 32'h5555_0005);
    dbg_line = 2'd1;
    apply(3'b010);
    check("R2 first wait", req_ok, 3'b000);
    @(negedge clk);
    check("R3 word unchanged during wait", view[63:32], 32'h0);
    req_valid = 3'b010; side_valid = 1'b1; side_addr = 4'd9; side_data = 32'h9999_0009;
    #1;
    check("R2 second wait", req_ok, 3'b000);
    check("R8 side ok same cycle", side_ok, 1'b1);
    @(negedge clk);
    side_valid = 1'b0; dbg_line = 2'd2;
    #1;
    check("R8 R10 side data visible", view[63:32], 32'h9999_0009);
    check("R9 third wait unaffected", req_ok, 3'b000);
    @(negedge clk);
    dbg_line = 2'd1;
    #1;
    check("R3 word unchanged before ok", view[63:32], 32'h0);
    check("R2 R9 ok on fourth presentation", req_ok, 3'b010);
    @(negedge clk);
    req_valid = '0;
    #1;
    check("R2 write after ok", view[63:32], 32'h5555_0005);

    // R11: side and owner hit the same word at the same edge
    do_reset();
    set_req(1, 4'd12, 32'hAAAA_000C);
    for (int k = 0; k < DELAY; k++) apply(3'b010);
    @(negedge clk);
    side_valid = 1'b1; side_addr = 4'd12; side_data = 32'hBEEF_000C;
    #1;
    check("R11 owner ok", req_ok, 3'b010);
    @(negedge clk);
    side_valid = 1'b0; req_valid = '0; dbg_line = 2'd3;
    #1;
    check("R11 side data kept", view[31:0], 32'hBEEF_000C);

    // R7: zero latency instance
    do_reset();
    set_req(0, 4'd3, 32'h3333_0003);
    apply(3'b001);
    check("R7 immediate ok", req_ok0, 3'b001);
    @(negedge clk);
    req_valid = '0; dbg_line = 2'd0;
    #1;
    check("R7 R10 write visible", view0[127:96], 32'h3333_0003);
    set_req(1, 4'd7, 32'h7777_0007);
    apply(3'b011);
    check("R4 R6 lower index first", req_ok0, 3'b001);
    apply(3'b010);
    check("R4 next owner served", req_ok0, 3'b010);
    @(negedge clk);
    req_valid = '0; dbg_line = 2'd1;
    #1;
    check("R7 R10 second write", view0[127:96], 32'h7777_0007);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule